// File: doc/BRIEF.md
# Legacy VGA Memory Window Decoder

This block classifies a memory address against the 128 KB legacy video window at 0x000A_0000 to 0x000B_FFFF. For addresses inside that window it picks one destination: the integrated graphics engine, the PCI Express port, or the default south link. The window has three parts: a low colour part, a monochrome part and a high colour part. The monochrome part can be sent somewhere other than the rest of the window.

Integrated graphics, when enabled, always takes precedence. With graphics disabled, two steering inputs decide between PCI Express and the south link. One routes the window to PCI Express. The other marks a monochrome adapter as present, which sends the monochrome part to the south link. The block also raises a main-memory flag for addresses from 16 MB up to a programmable top of low memory. The decode is combinational, and its result is registered once, so each request produces its answer one cycle later.

Top module: `vga_win_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_dest, out_window_hit and out_main_mem are all zero.
- R2: out_valid is high in exactly those cycles that follow a cycle with in_valid high, so the latency is one cycle.
- R3: out_window_hit is 1 exactly when the request address lies in 0x000A_0000..0x000B_FFFF. When it is 1, out_dest is nonzero. Addresses 0x0009_FFFF and 0x000C_0000 do not hit.
- R4: With igfx_en = 1, every window address, including the monochrome part, gives out_dest = 3'b001 (graphics), whatever the two steering inputs are.
- R5: With igfx_en = 0 and vga_route_en = 1, window addresses outside 0x000B_0000..0x000B_7FFF give out_dest = 3'b010 (PCI Express). The same holds for monochrome addresses when mono_present = 0.
- R6: With igfx_en = 0, vga_route_en = 1 and mono_present = 1, addresses in 0x000B_0000..0x000B_7FFF give out_dest = 3'b100 (south link), while 0x000A_FFFF and 0x000B_8000 still go to PCI Express.
- R7: With igfx_en = 0 and vga_route_en = 0, every window address gives out_dest = 3'b100 (south link), and mono_present has no effect.
- R8: out_main_mem is 1 exactly when 0x0100_0000 <= address < mem_top. It is never 1 together with out_window_hit. When mem_top <= 0x0100_0000, no address sets it.
- R9: out_dest is one-hot or zero. It is zero for addresses outside the window. In a cycle that follows in_valid low, all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request address is valid this cycle |
| in_addr | input | 32 | Request memory address |
| igfx_en | input | 1 | Integrated graphics enabled |
| vga_route_en | input | 1 | Send the legacy window to PCI Express |
| mono_present | input | 1 | Monochrome adapter sits on the south link |
| mem_top | input | 32 | Top of low memory (exclusive bound) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_dest | output | 3 | One-hot destination: 001 graphics, 010 PCI Express, 100 south link |
| out_window_hit | output | 1 | Address was inside the legacy window |
| out_main_mem | output | 1 | Address was in main memory |

## Verification
Two functions can apply to one request at the same time: graphics precedence and the monochrome split. Both apply when a monochrome address arrives with igfx_en, vga_route_en and mono_present all set. The bench provokes this case and expects the graphics code, because precedence must override the split. It also clears igfx_en on the next request to the same address and expects the south link in the very next result. A scoreboard model built from the requirements judges every cycle, including the edges of each part of the window and the mem_top boundary.

// File: rtl/vga_dec_pkg.sv
package vga_dec_pkg;

    typedef enum logic [2:0] {
        DST_NONE  = 3'b000,
        DST_IGFX  = 3'b001,
        DST_PCIE  = 3'b010,
        DST_SOUTH = 3'b100
    } dest_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SEG_A,
        RG_MONO,
        RG_SEG_B,
        RG_MAIN
    } region_e;

    typedef struct packed {
        logic  valid;
        dest_e dest;
        logic  hit;
        logic  main;
    } dec_out_t;

endpackage

// File: rtl/vga_range_cls.sv
module vga_range_cls
    import vga_dec_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_LO    = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] MONO_LO   = 32'h000B_0000,
    parameter logic [ADDR_W-1:0] SEGB_LO   = 32'h000B_8000,
    parameter logic [ADDR_W-1:0] WIN_HI    = 32'h000B_FFFF,
    parameter logic [ADDR_W-1:0] MEM_FLOOR = 32'h0100_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mem_top,
    output region_e           region
);
    localparam int N_SUB = 3;
    localparam logic [ADDR_W-1:0] SUB_LO [N_SUB] = '{WIN_LO, MONO_LO, SEGB_LO};
    localparam logic [ADDR_W-1:0] SUB_HI [N_SUB] = '{MONO_LO - 1'b1, SEGB_LO - 1'b1, WIN_HI};

    logic [N_SUB-1:0] sub_hit;
    logic             main_hit;

    // one comparator pair per sub-range of the window
    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
        assign sub_hit[g] = (addr >= SUB_LO[g]) && (addr <= SUB_HI[g]);
    end

    assign main_hit = (addr >= MEM_FLOOR) && (addr < mem_top);

    always_comb begin
        region = RG_NONE;
        if (sub_hit[0])      region = RG_SEG_A;
        else if (sub_hit[1]) region = RG_MONO;
        else if (sub_hit[2]) region = RG_SEG_B;
        else if (main_hit)   region = RG_MAIN;
    end

endmodule

// File: rtl/vga_steer.sv
module vga_steer
    import vga_dec_pkg::*;
(
    input  region_e region,
    input  logic    igfx_en,
    input  logic    vga_route_en,
    input  logic    mono_present,
    output dest_e   dest,
    output logic    win_hit
);
    always_comb begin
        dest    = DST_NONE;
        win_hit = 1'b0;
        case (region)
            RG_SEG_A, RG_MONO, RG_SEG_B: begin
                win_hit = 1'b1;
                if (igfx_en)                            dest = DST_IGFX;
                else if (!vga_route_en)                 dest = DST_SOUTH;
                else if (region == RG_MONO && mono_present) dest = DST_SOUTH;
                else                                    dest = DST_PCIE;
            end
            default: begin
                dest    = DST_NONE;
                win_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vga_win_decoder.sv
module vga_win_decoder
    import vga_dec_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_LO    = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] MONO_LO   = 32'h000B_0000,
    parameter logic [ADDR_W-1:0] SEGB_LO   = 32'h000B_8000,
    parameter logic [ADDR_W-1:0] WIN_HI    = 32'h000B_FFFF,
    parameter logic [ADDR_W-1:0] MEM_FLOOR = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              igfx_en,
    input  logic              vga_route_en,
    input  logic              mono_present,
    input  logic [ADDR_W-1:0] mem_top,
    output logic              out_valid,
    output logic [2:0]        out_dest,
    output logic              out_window_hit,
    output logic              out_main_mem
);
    region_e  region;
    dest_e    steer_dest;
    logic     steer_hit;
    dec_out_t res_d, res_q;

    vga_range_cls #(
        .ADDR_W    (ADDR_W),
        .WIN_LO    (WIN_LO),
        .MONO_LO   (MONO_LO),
        .SEGB_LO   (SEGB_LO),
        .WIN_HI    (WIN_HI),
        .MEM_FLOOR (MEM_FLOOR)
    ) u_cls (
        .addr    (in_addr),
        .mem_top (mem_top),
        .region  (region)
    );

    vga_steer u_steer (
        .region       (region),
        .igfx_en      (igfx_en),
        .vga_route_en (vga_route_en),
        .mono_present (mono_present),
        .dest         (steer_dest),
        .win_hit      (steer_hit)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.dest  = steer_dest;
            res_d.hit   = steer_hit;
            res_d.main  = (region == RG_MAIN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid      = res_q.valid;
    assign out_dest       = res_q.dest;
    assign out_window_hit = res_q.hit;
    assign out_main_mem   = res_q.main;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))) else $error("latency"); // R2
    AST_HIT_HAS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_window_hit == (out_dest != 3'b000)) else $error("hit without dest"); // R3
    AST_IGFX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(igfx_en) && out_window_hit) |-> (out_dest == 3'b001)) else $error("igfx"); // R4
    AST_MONO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && !igfx_en && vga_route_en && mono_present
                               && in_addr >= MONO_LO && in_addr < SEGB_LO))
        |-> (out_dest == 3'b100)) else $error("mono split"); // R6
    AST_NO_DUAL_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_window_hit && out_main_mem)) else $error("overlap"); // R8
    AST_DEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_dest)) else $error("dest not onehot"); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_dest == 3'b000 && !out_window_hit && !out_main_mem)) else $error("idle"); // R9

endmodule

// File: tb/sim_vga_win_decoder.sv
module sim_vga_win_decoder;

    typedef struct {
        logic       valid;
        logic [2:0] dest;
        logic       hit;
        logic       main;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        igfx_en = 1'b0;
    logic        vga_route_en = 1'b0;
    logic        mono_present = 1'b0;
    logic [31:0] mem_top = 32'h2000_0000;
    logic        out_valid;
    logic [2:0]  out_dest;
    logic        out_window_hit;
    logic        out_main_mem;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    vga_win_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .igfx_en(igfx_en), .vga_route_en(vga_route_en), .mono_present(mono_present),
        .mem_top(mem_top), .out_valid(out_valid), .out_dest(out_dest),
        .out_window_hit(out_window_hit), .out_main_mem(out_main_mem)
    );

    function automatic exp_t model(logic v, logic [31:0] a, logic ig, logic ve,
                                   logic mp, logic [31:0] top);
        exp_t e;
        e.valid = 1'b0; e.dest = 3'b000; e.hit = 1'b0; e.main = 1'b0; e.tag = "R9";
        if (v) begin
            e.valid = 1'b1;
            if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF) begin
                e.hit = 1'b1;
                if (ig)                                           begin e.dest = 3'b001; e.tag = "R4"; end
                else if (!ve)                                     begin e.dest = 3'b100; e.tag = "R7"; end
                else if (mp && a >= 32'h000B_0000 && a <= 32'h000B_7FFF) begin e.dest = 3'b100; e.tag = "R6"; end
                else                                              begin e.dest = 3'b010; e.tag = "R5"; end
            end else if (a >= 32'h0100_0000 && a < top) begin
                e.main = 1'b1; e.tag = "R8";
            end else begin
                e.tag = "R3 R8";
            end
        end
        return e;
    endfunction

    task automatic drive(logic v, logic [31:0] a, logic ig, logic ve, logic mp, logic [31:0] top);
        @(negedge clk);
        in_valid = v; in_addr = a; igfx_en = ig; vga_route_en = ve;
        mono_present = mp; mem_top = top;
        sb_q.push_back(model(v, a, ig, ve, mp, top));
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (out_valid !== e.valid) begin
                    n_bad++;
                    $display("FAIL R2 (%s): out_valid=%b expected %b", e.tag, out_valid, e.valid);
                end else if (out_dest !== e.dest || out_window_hit !== e.hit || out_main_mem !== e.main) begin
                    n_bad++;
                    $display("FAIL %s: dest=%b hit=%b main=%b expected dest=%b hit=%b main=%b",
                             e.tag, out_dest, out_window_hit, out_main_mem, e.dest, e.hit, e.main);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] edges [8];
        edges = '{32'h0009_FFFF, 32'h000A_0000, 32'h000A_FFFF, 32'h000B_0000,
                  32'h000B_7FFF, 32'h000B_8000, 32'h000B_FFFF, 32'h000C_0000};

        // R1: reset holds outputs low even with a request present
        in_valid = 1'b1; in_addr = 32'h000A_0000; igfx_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if (out_valid !== 1'b0 || out_dest !== 3'b000 || out_window_hit !== 1'b0 || out_main_mem !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%b dest=%b hit=%b main=%b expected all zero",
                     out_valid, out_dest, out_window_hit, out_main_mem);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        n_cmp++;
        if (out_valid !== 1'b0 || out_dest !== 3'b000) begin
            n_bad++;
            $display("FAIL R1: first cycle valid=%b dest=%b expected 0/000", out_valid, out_dest);
        end

        // R3-R7: every sub-range edge under each steering combination
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 8; k++) begin
                drive(1'b1, edges[k], f[2], f[1], f[0], 32'h2000_0000);
            end
        end

        // R4 vs R6 in back-to-back cycles: precedence, then split
        drive(1'b1, 32'h000B_4000, 1'b1, 1'b1, 1'b1, 32'h2000_0000);
        drive(1'b1, 32'h000B_4000, 1'b0, 1'b1, 1'b1, 32'h2000_0000);
        drive(1'b0, 32'h000B_4000, 1'b0, 1'b1, 1'b1, 32'h2000_0000); // R9 idle
        drive(1'b1, 32'h000B_4000, 1'b0, 1'b1, 1'b0, 32'h2000_0000); // R5

        // R8: main memory bounds
        drive(1'b1, 32'h00FF_FFFF, 1'b0, 1'b1, 1'b0, 32'h2000_0000);
        drive(1'b1, 32'h0100_0000, 1'b0, 1'b1, 1'b0, 32'h2000_0000);
        drive(1'b1, 32'h1FFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h2000_0000);
        drive(1'b1, 32'h2000_0000, 1'b0, 1'b1, 1'b0, 32'h2000_0000);
        drive(1'b1, 32'h0100_0000, 1'b0, 1'b1, 1'b0, 32'h0100_0000);
        drive(1'b1, 32'h0200_0000, 1'b0, 1'b1, 1'b0, 32'h0080_0000);
        drive(1'b1, 32'h000A_8000, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);

        // R2/R9: gaps between requests
        drive(1'b0, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 32'h2000_0000);
        drive(1'b1, 32'h000A_0000, 1'b0, 1'b0, 1'b0, 32'h2000_0000);
        drive(1'b0, 32'h000A_0000, 1'b1, 1'b0, 1'b0, 32'h2000_0000);

        // mixed pseudo-random traffic around the regions
        for (int i = 0; i < 400; i++) begin
            logic [31:0] base, a;
            logic [3:0]  sel;
            sel = 4'($urandom_range(0, 7));
            case (sel)
                4'd0:    base = 32'h000A_0000;
                4'd1:    base = 32'h000B_0000;
                4'd2:    base = 32'h000B_8000;
                4'd3:    base = 32'h0100_0000;
                4'd4:    base = 32'h3000_0000;
                default: base = 32'h0009_8000;
            endcase
            a = base + 32'($urandom_range(0, 32'h0001_0000));
            drive(1'($urandom_range(0, 3) != 0), a, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  32'h0100_0000 + 32'($urandom_range(0, 32'h3000_0000)));
        end

        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h2000_0000);
        repeat (4) @(posedge clk);
        #3;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d results outstanding, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule